// File: doc/BRIEF.md
# Fractional MAC Rounding Unit

This block reduces the wide intermediate values of a fixed-point multiply-accumulate datapath to their final widths. It has two independent paths. The product path takes the 64-bit signed product of two 32-bit fractional operands and keeps its upper 40 bits. The store path takes a 48-bit accumulator and forms the 32-bit value written to a register. A 48-bit accumulator holds 8 extension bits above a 40-bit value.

Three mode inputs set the behaviour of both paths. `md_frac` selects fractional or integer data. `md_round` selects rounding or truncation of the product. `md_narrow` selects unsigned data in integer mode and 16-bit store results in fractional mode. In fractional mode all data is signed. Every rounding step uses round-half-to-even. A store whose extension bits overflow the kept field, or a round-up that would pass the most positive code, clamps to the nearest representable limit.

Both paths are combinational. With the default parameter, one output register stage follows them.

Top module: `mac_round_unit`

## Requirements
- R1: In integer mode (`md_frac`=0), `store_out` equals `acc_in[31:0]` and `prod_out` equals `prod_in[63:24]`. Neither path rounds in this mode, whatever `md_narrow` and `md_round` are set to.
- R2: In fractional mode with `md_round`=0, `prod_out` equals `prod_in[63:24]`. The low 24 bits are dropped.
- R3: In fractional mode with `md_round`=1, `prod_out` is `prod_in[63:24]` rounded on `prod_in[23:0]`. Below 24'h800000 the value is kept. Above 24'h800000 it is incremented. At exactly 24'h800000 it is incremented only when bit 24 is 1, so the result LSB is 0.
- R4: A product round-up from 40'h7F_FFFF_FFFF gives 40'h7F_FFFF_FFFF.
- R5: In fractional mode with `md_narrow`=0 and `md_round`=1, `store_out` is `acc_in[39:8]` rounded half-to-even on `acc_in[7:0]`. The half point is 8'h80.
- R6: In fractional mode with `md_narrow`=0 and `md_round`=0, `store_out` is `acc_in[39:8]` truncated.
- R7: In fractional mode with `md_narrow`=1, `store_out` is `acc_in[39:24]` rounded half-to-even on `acc_in[23:0]`, then sign-extended to 32 bits. This rounding applies for either value of `md_round`.
- R8: In fractional mode, if `acc_in[47:40]` is not eight copies of `acc_in[39]`, `store_out` saturates according to `acc_in[47]`. A positive accumulator gives 32'h7FFFFFFF, or 32'h00007FFF in 16-bit mode. A negative one gives 32'h80000000, or 32'hFFFF8000 in 16-bit mode.
- R9: A store round-up from the most positive kept field gives that field's most positive value: 32'h7FFFFFFF, or 32'h00007FFF in 16-bit mode.
- R10: Outputs appear one clock after their inputs. While `rst_n` is low at a rising edge, both outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| md_narrow | input | 1 | Unsigned select in integer mode; 16-bit store select in fractional mode |
| md_frac | input | 1 | 1 = fractional, 0 = integer |
| md_round | input | 1 | 1 = round the product, 0 = truncate it |
| prod_in | input | 64 | Signed product of two 32-bit operands |
| acc_in | input | 48 | Accumulator value to store |
| prod_out | output | 40 | Reduced product |
| store_out | output | 32 | Value for the register write |

## Verification
The embedded properties check several behaviours on every cycle: the integer-mode pass-through, exact product truncation, even results on product ties, a rounded product that never moves more than one step from the truncated one, sign extension of 16-bit stores, and clamping of positive overflows. Only the bench's scenarios can confirm the complete arithmetic. This covers the exact rounded and saturated values for every combination of the three mode bits, ties whose kept LSB is odd or even, negative overflow, and the one-cycle latency and reset clearing. The bench computes every expected value as floor division followed by a clamp to the signed output range. This is a different formulation from the bit-field logic in the design.

// File: rtl/mac_rnd_pkg.sv
// Package: shared mode type for the MAC rounding unit.
// Assumes: the three mode inputs are static for the cycle they are sampled.
package mac_rnd_pkg;
    typedef struct packed {
        logic narrow;   // unsigned (integer) or 16-bit store (fractional)
        logic frac;     // fractional data
        logic round;    // round the product instead of truncating it
    } rnd_mode_t;
endpackage

// File: rtl/mac_rne_trim.sv
// Module: mac_rne_trim
// Drops DROP_W low bits of a signed value and optionally rounds half-to-even.
// A round-up from the most positive kept code holds that code (clamp).
// Assumes: DROP_W >= 1 and IN_W > DROP_W.
module mac_rne_trim #(
    parameter int IN_W   = 40,
    parameter int DROP_W = 8,
    localparam int KEEP_W = IN_W - DROP_W
) (
    input  logic [IN_W-1:0]   din,
    input  logic              rnd_en,
    output logic [KEEP_W-1:0] dout
);
    localparam logic [DROP_W-1:0] HALF    = DROP_W'(1) << (DROP_W - 1);
    localparam logic [KEEP_W-1:0] MAX_POS = {1'b0, {(KEEP_W-1){1'b1}}};

    logic [KEEP_W-1:0] keep_f;
    logic [DROP_W-1:0] lost_f;
    logic              bump;

    assign keep_f = din[IN_W-1:DROP_W];
    assign lost_f = din[DROP_W-1:0];

    // Decide the increment from the discarded bits and apply it with clamping.
    always_comb begin
        bump = rnd_en && ((lost_f > HALF) || ((lost_f == HALF) && keep_f[0]));
        if (bump && (keep_f != MAX_POS))
            dout = keep_f + KEEP_W'(1);
        else
            dout = keep_f;
    end
endmodule

// File: rtl/mac_prod_path.sv
// Module: mac_prod_path
// Reduces a full-width signed product to its upper KEEP_W bits.
// Rounds only in fractional mode with the round bit set.
// Assumes: the product is a two's complement value of PROD_W bits.
module mac_prod_path
    import mac_rnd_pkg::*;
#(
    parameter int PROD_W = 64,
    parameter int KEEP_W = 40
) (
    input  rnd_mode_t         mode,
    input  logic [PROD_W-1:0] prod,
    output logic [KEEP_W-1:0] res
);
    logic rnd_en;

    // Round only for fractional data with rounding requested.
    assign rnd_en = mode.frac & mode.round;

    mac_rne_trim #(.IN_W(PROD_W), .DROP_W(PROD_W - KEEP_W)) u_trim (
        .din    (prod),
        .rnd_en (rnd_en),
        .dout   (res)
    );
endmodule

// File: rtl/mac_store_path.sv
// Module: mac_store_path
// Forms the register-write value from an accumulator of ACC_W bits.
// The accumulator holds GUARD_W extension bits over a value of VAL_W bits.
// Fractional mode keeps a WIDE_W or NARROW_W field from the top of the value,
// then rounds or truncates it and saturates it.
// Integer mode passes the low WIDE_W bits.
// Assumes: NARROW_W < WIDE_W < VAL_W.
module mac_store_path
    import mac_rnd_pkg::*;
#(
    parameter int ACC_W    = 48,
    parameter int GUARD_W  = 8,
    parameter int WIDE_W   = 32,
    parameter int NARROW_W = 16
) (
    input  rnd_mode_t         mode,
    input  logic [ACC_W-1:0]  acc,
    output logic [WIDE_W-1:0] res
);
    localparam int VAL_W  = ACC_W - GUARD_W;
    localparam int PAD_W  = WIDE_W - NARROW_W;
    localparam logic [WIDE_W-1:0] WIDE_POS   = {1'b0, {(WIDE_W-1){1'b1}}};
    localparam logic [WIDE_W-1:0] WIDE_NEG   = {1'b1, {(WIDE_W-1){1'b0}}};
    localparam logic [WIDE_W-1:0] NARROW_POS = {{(PAD_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
    localparam logic [WIDE_W-1:0] NARROW_NEG = {{(PAD_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};

    logic [WIDE_W-1:0]   wide_f;
    logic [NARROW_W-1:0] narrow_f;
    logic                ext_ok;
    logic                acc_neg;

    mac_rne_trim #(.IN_W(VAL_W), .DROP_W(VAL_W - WIDE_W)) u_wide (
        .din    (acc[VAL_W-1:0]),
        .rnd_en (mode.round),
        .dout   (wide_f)
    );

    mac_rne_trim #(.IN_W(VAL_W), .DROP_W(VAL_W - NARROW_W)) u_narrow (
        .din    (acc[VAL_W-1:0]),
        .rnd_en (1'b1),
        .dout   (narrow_f)
    );

    // Extension bits must replicate the sign of the kept value.
    assign ext_ok  = (acc[ACC_W-1:VAL_W] == {GUARD_W{acc[VAL_W-1]}});
    assign acc_neg = acc[ACC_W-1];

    // Select the pass-through, saturated or rounded result.
    always_comb begin
        if (!mode.frac)
            res = acc[WIDE_W-1:0];
        else if (mode.narrow) begin
            if (!ext_ok)
                res = acc_neg ? NARROW_NEG : NARROW_POS;
            else
                res = {{PAD_W{narrow_f[NARROW_W-1]}}, narrow_f};
        end else begin
            if (!ext_ok)
                res = acc_neg ? WIDE_NEG : WIDE_POS;
            else
                res = wide_f;
        end
    end
endmodule

// File: rtl/mac_round_unit.sv
// Module: mac_round_unit (top)
// Product and store rounding paths of a fixed-point MAC datapath.
// OUT_REG=1 adds one output register stage; OUT_REG=0 leaves the block combinational.
// Assumes: synchronous active-low reset; inputs are stable around the rising edge.
module mac_round_unit
    import mac_rnd_pkg::*;
#(
    parameter int OP_W     = 32,
    parameter int KEEP_W   = 40,
    parameter int GUARD_W  = 8,
    parameter int NARROW_W = 16,
    parameter bit OUT_REG  = 1'b1,
    localparam int PROD_W  = 2 * OP_W,
    localparam int ACC_W   = KEEP_W + GUARD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              md_narrow,
    input  logic              md_frac,
    input  logic              md_round,
    input  logic [PROD_W-1:0] prod_in,
    input  logic [ACC_W-1:0]  acc_in,
    output logic [KEEP_W-1:0] prod_out,
    output logic [OP_W-1:0]   store_out
);
    localparam int PDROP_W = PROD_W - KEEP_W;
    localparam logic [PDROP_W-1:0] PHALF   = PDROP_W'(1) << (PDROP_W - 1);
    localparam logic [KEEP_W-1:0]  KMAX    = {1'b0, {(KEEP_W-1){1'b1}}};
    localparam logic [OP_W-1:0]    WMAX    = {1'b0, {(OP_W-1){1'b1}}};

    rnd_mode_t         mode;
    logic [KEEP_W-1:0] prod_c;
    logic [OP_W-1:0]   store_c;

    assign mode = '{narrow: md_narrow, frac: md_frac, round: md_round};

    mac_prod_path #(.PROD_W(PROD_W), .KEEP_W(KEEP_W)) u_prod (
        .mode (mode),
        .prod (prod_in),
        .res  (prod_c)
    );

    mac_store_path #(.ACC_W(ACC_W), .GUARD_W(GUARD_W), .WIDE_W(OP_W),
                     .NARROW_W(NARROW_W)) u_store (
        .mode (mode),
        .acc  (acc_in),
        .res  (store_c)
    );

    generate
        if (OUT_REG) begin : g_reg
            // Register both results; reset clears them.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prod_out  <= '0;
                    store_out <= '0;
                end else begin
                    prod_out  <= prod_c;
                    store_out <= store_c;
                end
            end
        end else begin : g_comb
            assign prod_out  = prod_c;
            assign store_out = store_c;
        end
    endgenerate

    // R1
    int_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !md_frac |-> (store_c == acc_in[OP_W-1:0]) && (prod_c == prod_in[PROD_W-1:PDROP_W]));

    // R2
    trunc_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (md_frac && !md_round) |-> prod_c == prod_in[PROD_W-1:PDROP_W]);

    // R3
    tie_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (md_frac && md_round && prod_in[PDROP_W-1:0] == PHALF
         && prod_in[PROD_W-1:PDROP_W] != KMAX) |-> !prod_c[0]);

    // R3
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (md_frac && md_round) |-> (prod_c == prod_in[PROD_W-1:PDROP_W])
            || (prod_c == prod_in[PROD_W-1:PDROP_W] + KEEP_W'(1)));

    // R7
    narrow_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (md_frac && md_narrow) |-> store_c[OP_W-1:NARROW_W-1] == {(OP_W-NARROW_W+1){store_c[NARROW_W-1]}});

    // R8
    pos_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (md_frac && !md_narrow && !acc_in[ACC_W-1] && acc_in[ACC_W-1:KEEP_W-1] != '0)
            |-> store_c == WMAX);
endmodule

// File: tb/mac_round_unit_test.sv
// Bench: sweeps all eight mode combinations with directed tie, overflow and
// random patterns. Expected values come from floor division and a signed clamp.
module mac_round_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        md_narrow = 1'b0, md_frac = 1'b0, md_round = 1'b0;
    logic [63:0] prod_in = '0;
    logic [47:0] acc_in = '0;
    logic [39:0] prod_out;
    logic [31:0] store_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mac_round_unit uut (
        .clk(clk), .rst_n(rst_n), .md_narrow(md_narrow), .md_frac(md_frac),
        .md_round(md_round), .prod_in(prod_in), .acc_in(acc_in),
        .prod_out(prod_out), .store_out(store_out)
    );

    // Floor-divide by 2^d, optionally rounding half to even.
    function automatic longint rne(longint v, int d, bit en);
        longint q, rem, half;
        q = v >>> d;
        if (en) begin
            rem  = v & ((64'sd1 <<< d) - 64'sd1);
            half = 64'sd1 <<< (d - 1);
            if (rem > half || (rem == half && q[0])) q = q + 64'sd1;
        end
        return q;
    endfunction

    // Clamp to the signed range of w bits.
    function automatic longint clampw(longint v, int w);
        longint mx, mn;
        mx = (64'sd1 <<< (w - 1)) - 64'sd1;
        mn = -(64'sd1 <<< (w - 1));
        if (v > mx) return mx;
        if (v < mn) return mn;
        return v;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one vector, wait one edge, compare both outputs.
    task automatic apply(bit n, bit f, bit r, logic [63:0] p, logic [47:0] a);
        longint ps, as_, pe, se, pr, sr;
        logic [39:0] pexp;
        logic [31:0] sexp;
        string ptag, stag;
        md_narrow = n; md_frac = f; md_round = r; prod_in = p; acc_in = a;
        ps  = longint'($signed(p));
        as_ = longint'($signed(a));
        pr  = rne(ps, 24, f && r);
        pe  = clampw(pr, 40);
        pexp = pe[39:0];
        if (!f) ptag = "R1";
        else if (!r) ptag = "R2";
        else if (pr != pe) ptag = "R4";
        else ptag = "R3";
        if (!f) begin
            sexp = a[31:0]; stag = "R1";
        end else begin
            if (n) begin
                sr = rne(as_, 24, 1'b1); se = clampw(sr, 16); stag = "R7";
            end else begin
                sr = rne(as_, 8, r); se = clampw(sr, 32);
                stag = r ? "R5" : "R6";
            end
            sexp = se[31:0];
            if (sr != se) begin
                if (as_ != clampw(as_, 40)) stag = "R8";
                else stag = "R9";
            end
        end
        @(negedge clk);
        check(ptag, {24'h0, prod_out}, {24'h0, pexp});
        check(stag, {32'h0, store_out}, {32'h0, sexp});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] p;
        logic [47:0] a;
        @(negedge clk);
        // R10: reset clears outputs even with live inputs
        md_frac = 1'b0; prod_in = 64'hFFFF_FFFF_FFFF_FFFF; acc_in = 48'hFFFF_FFFF_FFFF;
        repeat (2) @(negedge clk);
        check("R10", {24'h0, prod_out}, 64'h0);
        check("R10", {32'h0, store_out}, 64'h0);
        rst_n = 1'b1;
        // R10: one-cycle latency
        apply(1'b0, 1'b0, 1'b0, 64'h1234_5678_9ABC_DEF0, 48'h0000_CAFE_F00D);

        for (int m = 0; m < 8; m++) begin
            bit n, f, r;
            n = m[2]; f = m[1]; r = m[0];
            // product ties, odd and even kept LSB; above and below half
            apply(n, f, r, 64'h0000_0001_0380_0000, 48'h0000_1234_5680);
            apply(n, f, r, 64'h0000_0001_0280_0000, 48'h0000_1234_5780);
            apply(n, f, r, 64'h0000_0001_0280_0001, 48'h0000_1234_5781);
            apply(n, f, r, 64'h0000_0001_027F_FFFF, 48'h0000_1234_567F);
            apply(n, f, r, 64'hFFFF_FFFF_FF80_0000, 48'h00FF_FFFF_FF80);
            apply(n, f, r, 64'hFFFF_FFFF_FE80_0000, 48'h00FF_FFFE_FF80);
            // R4 and R9: round-up from the most positive field
            apply(n, f, r, 64'h7FFF_FFFF_FF80_0000, 48'h007F_FFFF_FF80);
            apply(n, f, r, 64'h7FFF_FFFF_FFC0_0000, 48'h007F_FFFF_FFFF);
            // 16-bit ties
            apply(n, f, r, 64'h8000_0000_0000_0000, 48'h0000_0180_0000);
            apply(n, f, r, 64'h8000_0000_00FF_FFFF, 48'h0000_0280_0000);
            apply(n, f, r, 64'h0, 48'h007F_FF80_0000);
            // R8: overflowing extension, both signs
            apply(n, f, r, 64'h0, 48'h0100_0000_0000);
            apply(n, f, r, 64'h0, 48'h0080_0000_0000);
            apply(n, f, r, 64'h0, 48'hFF7F_FFFF_FFFF);
            apply(n, f, r, 64'h0, 48'h8000_0000_0000);
            apply(n, f, r, 64'h0, 48'hFF80_0000_0000);
            // random sweep with forced tie fields
            for (int i = 0; i < 400; i++) begin
                p = {$urandom, $urandom};
                a = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
                if (i % 4 == 1) p[23:0] = 24'h800000;
                if (i % 4 == 2) begin a[7:0] = 8'h80; a[23:8] = 16'h8000; end
                if (i % 3 != 0) a[47:40] = {8{a[39]}};
                apply(n, f, r, p, a);
            end
        end
        // R10: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", {24'h0, prod_out}, 64'h0);
        check("R10", {32'h0, store_out}, 64'h0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule